// File: doc/BRIEF.md
# Static Memory Wait-State Scheduler

This block sits between the access arbiter of an external static-memory controller and the waveform generator that drives the bus pins. For every pending access it decides whether one idle cycle must separate it from the access before it. It keeps a short record of the last access that started: its chip select, its direction, how that write was controlled, and whether it had zero hold cycles. It also watches write strobes from the configuration register file, which holds staged timing and mode settings for every chip select.

Three situations need an idle cycle. The first is a change of chip select. The second is a configuration reload: a validated rewrite of the staged settings must be copied into the active set before the next access uses it. The third is a read that follows directly after a strobe-controlled write with no hold, called here an early-read turnaround. When more than one of these holds, the block inserts a single idle cycle and reports the one with the highest priority. In the cycle that a reload is due, it pulses a load strobe so that the parameter store can copy the staged set into the active set.

The requester holds `acc_req` with the access attributes until `acc_go` is high at a clock edge. That edge is the cycle in which the access starts.

Top module: `smc_wait_sched`

## Requirements
- R1: After reset the block is not armed and holds no previous-access record, so the first access is granted with `acc_go` high in its first cycle and no wait, provided no mode-register write came before it.
- R2: When the pending access uses a different chip select from the last access that started, one wait cycle is issued with `wait_kind` = 2'b01. The access is granted in the next cycle.
- R3: A configuration write with `cfg_wr_reg` = 2'b11 (mode register) arms a reload, for any chip select. The next access to the same chip select as the previous access, or the first access when there is no previous one, gets one wait cycle with `wait_kind` = 2'b10.
- R4: Configuration writes with `cfg_wr_reg` = 2'b00, 2'b01 or 2'b10 (setup, pulse and cycle timing) do not arm a reload. A following access to the same chip select is granted without a wait.
- R5: When a reload is armed and the chip select changes, exactly one wait cycle is issued, with `wait_kind` = 2'b01 and `param_load` high. No second wait cycle follows.
- R6: `param_load` is high in exactly those wait cycles in which a reload is armed. The armed state then clears, unless a mode-register write arrives in that same cycle, in which case it stays armed for a later access.
- R7: A read (`acc_wr` = 0) that follows a write with `acc_wr_strobe` = 1 (controlled by the write-enable strobe) and `acc_hold` = 0 on the same chip select gets one wait with `wait_kind` = 2'b11. A previous write with non-zero hold, or one controlled by the chip select (`acc_wr_strobe` = 0), causes no such wait. The read's own control mode is not an input and does not matter.
- R8: Each access gets at most one wait cycle. After a wait cycle `acc_go` is high in the next cycle while `acc_req` is held. `acc_go` is never high in a wait cycle. When several conditions coincide, the priority is chip-select change, then reload, then early read.
- R9: While `acc_req` is low, `wait_req`, `acc_go` and `param_load` stay low. The previous-access record is kept through idle cycles and applies to the next access.
- R10: `wait_kind` reads 2'b00 in every cycle in which `wait_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_req | input | 1 | A pending access is presented and held until granted |
| acc_cs | input | CS_W | Chip select of the pending access |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_wr_strobe | input | 1 | For writes: 1 = controlled by the write-enable strobe, 0 = by the chip select |
| acc_hold | input | HOLD_W | Hold cycles of the pending write |
| cfg_wr_en | input | 1 | Configuration register write strobe |
| cfg_wr_reg | input | 2 | Register kind written: 00 setup, 01 pulse, 10 cycle, 11 mode |
| acc_go | output | 1 | Pending access starts at this clock edge |
| wait_req | output | 1 | This cycle is an inserted idle cycle |
| wait_kind | output | 2 | 00 none, 01 chip-select change, 10 reload, 11 early read |
| param_load | output | 1 | Copy the staged parameters into the active set |

## Verification
A lost or stale previous-access record shows up at the next granted access. The wait is either missing or spurious, or `wait_kind` names the wrong cause, and this is visible in the first cycle that access is presented. A reload flag that is stuck or cleared too early is seen on the next access to the same chip select, as a missing or extra `param_load` together with `wait_kind` 2'b10. A wrong wait-done flag shows up one cycle after a wait: either the grant never comes or a second wait follows. The reference model in the bench is compared with all four outputs on every clock, so each of these faults is reported within one cycle of the access that exposes it.

// File: rtl/smc_ws_pkg.sv
// Package: shared encodings for the static-memory wait-state scheduler.
// Assumes: a two-bit register-kind field from the configuration file.
package smc_ws_pkg;

    // Cause of an inserted idle cycle, also the priority order (low code wins).
    typedef enum logic [1:0] {
        WK_NONE   = 2'b00,
        WK_CSCHG  = 2'b01,
        WK_RELOAD = 2'b10,
        WK_EARLY  = 2'b11
    } wait_kind_t;

    // Register kinds reported with a configuration write strobe.
    localparam logic [1:0] REG_SETUP = 2'b00;
    localparam logic [1:0] REG_PULSE = 2'b01;
    localparam logic [1:0] REG_CYCLE = 2'b10;
    localparam logic [1:0] REG_MODE  = 2'b11;

endpackage

// File: rtl/smc_ws_history.sv
// Module: smc_ws_history
// Holds the record of the last access that started (chip select, direction,
// write control, zero-hold flag) and a flag saying the pending access has
// already received its wait cycle.
// Assumes: acc_go and wait_fire are never high together.
module smc_ws_history #(
    parameter int CS_W   = 2,
    parameter int HOLD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_go,
    input  logic              wait_fire,
    input  logic [CS_W-1:0]   acc_cs,
    input  logic              acc_wr,
    input  logic              acc_wr_strobe,
    input  logic [HOLD_W-1:0] acc_hold,
    output logic              prev_valid,
    output logic [CS_W-1:0]   prev_cs,
    output logic              prev_wr,
    output logic              prev_strobe,
    output logic              prev_nohold,
    output logic              waited
);

    logic hold_is_zero;

    // Reduce the hold count to the single fact the turnaround rule needs.
    always_comb begin
        hold_is_zero = (acc_hold == '0);
    end

    // Capture the attributes of an access at the edge where it starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_valid  <= 1'b0;
            prev_cs     <= '0;
            prev_wr     <= 1'b0;
            prev_strobe <= 1'b0;
            prev_nohold <= 1'b0;
        end else if (acc_go) begin
            prev_valid  <= 1'b1;
            prev_cs     <= acc_cs;
            prev_wr     <= acc_wr;
            prev_strobe <= acc_wr_strobe;
            prev_nohold <= hold_is_zero;
        end
    end

    // Mark that the pending access already had its one idle cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waited <= 1'b0;
        end else if (acc_go) begin
            waited <= 1'b0;
        end else if (wait_fire) begin
            waited <= 1'b1;
        end
    end

endmodule

// File: rtl/smc_ws_reload_arm.sv
// Module: smc_ws_reload_arm
// Arms a configuration reload when any mode register is written, and
// disarms it when the parameter load fires. A mode write in the load cycle
// wins, so a late update is kept for the next access.
// Assumes: timing-register writes are meant to wait for a mode write.
module smc_ws_reload_arm (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr_en,
    input  logic [1:0] cfg_wr_reg,
    input  logic       load_fire,
    output logic       armed
);
    import smc_ws_pkg::*;

    logic mode_write;

    // Only the mode register validates staged settings.
    always_comb begin
        mode_write = cfg_wr_en && (cfg_wr_reg == REG_MODE);
    end

    // Set on a validating write, clear on the load pulse, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (mode_write) begin
            armed <= 1'b1;
        end else if (load_fire) begin
            armed <= 1'b0;
        end
    end

endmodule

// File: rtl/smc_ws_decide.sv
// Module: smc_ws_decide
// Combinational wait decision for the pending access: detects chip-select
// change, armed reload and early-read turnaround, merges them into at most
// one idle cycle, and picks the reported cause by priority.
// Assumes: inputs from the history and arming registers are stable per cycle.
module smc_ws_decide #(
    parameter int CS_W = 2
) (
    input  logic            acc_req,
    input  logic [CS_W-1:0] acc_cs,
    input  logic            acc_wr,
    input  logic            prev_valid,
    input  logic [CS_W-1:0] prev_cs,
    input  logic            prev_wr,
    input  logic            prev_strobe,
    input  logic            prev_nohold,
    input  logic            waited,
    input  logic            armed,
    output logic            wait_req,
    output logic [1:0]      wait_kind,
    output logic            param_load,
    output logic            acc_go
);
    import smc_ws_pkg::*;

    logic       cs_change;
    logic       early_read;
    logic       need_wait;
    wait_kind_t kind;

    // Individual hazard detectors against the previous access.
    always_comb begin
        cs_change  = prev_valid && (acc_cs != prev_cs);
        early_read = prev_valid && prev_wr && prev_strobe && prev_nohold && !acc_wr;
    end

    // One idle cycle at most per access, cause chosen by fixed priority.
    always_comb begin
        need_wait = acc_req && !waited && (cs_change || armed || early_read);
        if (!need_wait) begin
            kind = WK_NONE;
        end else if (cs_change) begin
            kind = WK_CSCHG;
        end else if (armed) begin
            kind = WK_RELOAD;
        end else begin
            kind = WK_EARLY;
        end
    end

    // Drive the grant, the wait and the load strobe.
    always_comb begin
        wait_req   = need_wait;
        wait_kind  = kind;
        param_load = need_wait && armed;
        acc_go     = acc_req && !need_wait;
    end

endmodule

// File: rtl/smc_wait_sched.sv
// Module: smc_wait_sched (top)
// Decides idle cycles between consecutive static-memory accesses and pulses
// the staged-to-active parameter load during a reload wait.
// Assumes: the requester holds acc_req and attributes until acc_go.
module smc_wait_sched #(
    parameter int NUM_CS = 4,
    parameter int HOLD_W = 4,
    localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_req,
    input  logic [CS_W-1:0]   acc_cs,
    input  logic              acc_wr,
    input  logic              acc_wr_strobe,
    input  logic [HOLD_W-1:0] acc_hold,
    input  logic              cfg_wr_en,
    input  logic [1:0]        cfg_wr_reg,
    output logic              acc_go,
    output logic              wait_req,
    output logic [1:0]        wait_kind,
    output logic              param_load
);

    logic            prev_valid;
    logic [CS_W-1:0] prev_cs;
    logic            prev_wr;
    logic            prev_strobe;
    logic            prev_nohold;
    logic            waited;
    logic            armed;

    smc_ws_history #(.CS_W(CS_W), .HOLD_W(HOLD_W)) u_history (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc_go       (acc_go),
        .wait_fire    (wait_req),
        .acc_cs       (acc_cs),
        .acc_wr       (acc_wr),
        .acc_wr_strobe(acc_wr_strobe),
        .acc_hold     (acc_hold),
        .prev_valid   (prev_valid),
        .prev_cs      (prev_cs),
        .prev_wr      (prev_wr),
        .prev_strobe  (prev_strobe),
        .prev_nohold  (prev_nohold),
        .waited       (waited)
    );

    smc_ws_reload_arm u_arm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr_en (cfg_wr_en),
        .cfg_wr_reg(cfg_wr_reg),
        .load_fire (param_load),
        .armed     (armed)
    );

    smc_ws_decide #(.CS_W(CS_W)) u_decide (
        .acc_req    (acc_req),
        .acc_cs     (acc_cs),
        .acc_wr     (acc_wr),
        .prev_valid (prev_valid),
        .prev_cs    (prev_cs),
        .prev_wr    (prev_wr),
        .prev_strobe(prev_strobe),
        .prev_nohold(prev_nohold),
        .waited     (waited),
        .armed      (armed),
        .wait_req   (wait_req),
        .wait_kind  (wait_kind),
        .param_load (param_load),
        .acc_go     (acc_go)
    );

endmodule

// File: rtl/smc_wait_sched_chk.sv
// Module: smc_wait_sched_chk
// Port-level temporal checks for smc_wait_sched, attached by bind.
module smc_wait_sched_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       acc_req,
    input logic       cfg_wr_en,
    input logic [1:0] cfg_wr_reg,
    input logic       acc_go,
    input logic       wait_req,
    input logic [1:0] wait_kind,
    input logic       param_load
);

    AST_FIRST_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rst_n) && !(cfg_wr_en && cfg_wr_reg == 2'b11)) |=> !wait_req || !$past(!rst_n, 2)); // R1
    AST_ONE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        wait_req |=> !wait_req); // R8
    AST_GO_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_req && acc_req) ##1 acc_req |-> acc_go); // R8
    AST_NO_GO_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        wait_req |-> !acc_go); // R8
    AST_LOAD_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        param_load |-> wait_req); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_req |-> (!wait_req && !acc_go && !param_load)); // R9
    AST_KIND_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        !wait_req |-> (wait_kind == 2'b00)); // R10

endmodule

bind smc_wait_sched smc_wait_sched_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_req   (acc_req),
    .cfg_wr_en (cfg_wr_en),
    .cfg_wr_reg(cfg_wr_reg),
    .acc_go    (acc_go),
    .wait_req  (wait_req),
    .wait_kind (wait_kind),
    .param_load(param_load)
);

// File: tb/test_smc_wait_sched.sv
module test_smc_wait_sched;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_req = 1'b0;
    logic [1:0] acc_cs = '0;
    logic       acc_wr = 1'b0;
    logic       acc_wr_strobe = 1'b0;
    logic [3:0] acc_hold = '0;
    logic       cfg_wr_en = 1'b0;
    logic [1:0] cfg_wr_reg = '0;
    logic       acc_go;
    logic       wait_req;
    logic [1:0] wait_kind;
    logic       param_load;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    smc_wait_sched #(.NUM_CS(4), .HOLD_W(4)) i_smc_wait_sched (
        .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_cs(acc_cs),
        .acc_wr(acc_wr), .acc_wr_strobe(acc_wr_strobe), .acc_hold(acc_hold),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_reg(cfg_wr_reg), .acc_go(acc_go),
        .wait_req(wait_req), .wait_kind(wait_kind), .param_load(param_load)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, compared on every clock.
    bit       m_valid, m_wr, m_strb, m_nohold, m_armed, m_waited;
    int       m_cs;

    always @(negedge clk) begin
        if (!rst_n) begin
            m_valid = 0; m_armed = 0; m_waited = 0;
            m_cs = 0; m_wr = 0; m_strb = 0; m_nohold = 0;
        end else begin
            bit csc, er, w, ld, go;
            int k;
            string tg;
            csc = m_valid && (int'(acc_cs) != m_cs);
            er  = m_valid && m_wr && m_strb && m_nohold && !acc_wr;
            w   = acc_req && !m_waited && (csc || m_armed || er);
            k   = !w ? 0 : csc ? 1 : m_armed ? 2 : 3;
            ld  = w && m_armed;
            go  = acc_req && !w;
            tg  = (k == 1) ? "R2" : (k == 2) ? "R3" : (k == 3) ? "R7" : "R10";
            chk({tg, " wait_req"}, int'(wait_req), int'(w));
            chk({tg, " wait_kind"}, int'(wait_kind), k);
            chk("R6 param_load", int'(param_load), int'(ld));
            chk("R8 acc_go", int'(acc_go), int'(go));
            if (go) begin
                m_valid = 1; m_cs = int'(acc_cs); m_wr = acc_wr;
                m_strb = acc_wr_strobe; m_nohold = (acc_hold == 0); m_waited = 0;
            end else if (w) begin
                m_waited = 1;
            end
            if (cfg_wr_en && cfg_wr_reg == 2'b11) m_armed = 1;
            else if (ld) m_armed = 0;
        end
    end

    int r_waits, r_kind, r_loads;

    // Present one access, optionally with a mode write in its first cycle.
    task automatic access(input int cs, input bit wr, input bit strb,
                          input int hold, input bit mode_first);
        bit done = 0;
        acc_cs = cs[1:0]; acc_wr = wr; acc_wr_strobe = strb; acc_hold = hold[3:0];
        acc_req = 1;
        if (mode_first) begin cfg_wr_en = 1; cfg_wr_reg = 2'b11; end
        r_waits = 0; r_kind = 0; r_loads = 0;
        while (!done) begin
            @(negedge clk); #1;
            if (wait_req) begin r_waits++; r_kind = int'(wait_kind); end
            if (param_load) r_loads++;
            done = acc_go;
            @(posedge clk); #3;
            cfg_wr_en = 0;
        end
        acc_req = 0;
    endtask

    task automatic cfg(input int rg);
        cfg_wr_en = 1; cfg_wr_reg = rg[1:0];
        @(posedge clk); #3;
        cfg_wr_en = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #3; end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #3 rst_n = 1;
        @(negedge clk); #1;
        chk("R1 reset wait_req", int'(wait_req), 0);
        chk("R1 reset acc_go", int'(acc_go), 0);
        @(posedge clk); #3;
        access(0, 0, 0, 1, 0);  chk("R1 first access waits", r_waits, 0);
        access(1, 0, 0, 1, 0);  chk("R2 cs change waits", r_waits, 1);
        chk("R2 cs change kind", r_kind, 1);
        cfg(0); cfg(1); cfg(2);
        access(1, 0, 0, 1, 0);  chk("R4 timing writes no wait", r_waits, 0);
        cfg(3);
        access(1, 0, 0, 1, 0);  chk("R3 reload kind", r_kind, 2);
        chk("R3 reload one wait", r_waits, 1);
        chk("R6 reload load", r_loads, 1);
        access(1, 0, 0, 1, 0);  chk("R6 load cleared", r_loads, 0);
        cfg(3);
        access(2, 1, 1, 0, 0);  chk("R5 merged single wait", r_waits, 1);
        chk("R5 merged kind", r_kind, 1);
        chk("R5 merged load", r_loads, 1);
        access(2, 0, 0, 1, 0);  chk("R7 early read kind", r_kind, 3);
        access(2, 1, 1, 2, 0);
        access(2, 0, 1, 1, 0);  chk("R7 hold nonzero no wait", r_waits, 0);
        access(2, 1, 0, 0, 0);
        access(2, 0, 1, 0, 0);  chk("R7 cs-controlled write no wait", r_waits, 0);
        idle(1);
        @(negedge clk); #1;
        chk("R9 idle no wait", int'(wait_req), 0);
        chk("R9 idle no go", int'(acc_go), 0);
        idle(4);
        access(3, 1, 1, 0, 0);  chk("R9 record kept cs change", r_kind, 1);
        cfg(3);
        access(3, 0, 0, 0, 0);  chk("R8 reload over early read", r_kind, 2);
        chk("R8 single wait", r_waits, 1);
        cfg(3);
        access(3, 0, 0, 0, 1);  chk("R6 load with rearm", r_loads, 1);
        access(3, 0, 0, 0, 0);  chk("R6 rearmed reload", r_kind, 2);
        access(3, 0, 0, 0, 0);  chk("R6 rearm consumed", r_waits, 0);
        for (int i = 0; i < 400; i++) begin
            int r = $urandom % 8;
            if (r == 0) cfg($urandom % 4);
            else if (r == 1) idle(1 + $urandom % 3);
            else access($urandom % 4, 1'($urandom % 2), 1'($urandom % 2),
                        $urandom % 3, ($urandom % 6) == 0);
        end
        idle(2);
        finish_run();
    end

endmodule